// File: doc/BRIEF.md
# Bank Pin-Event Interrupt Controller

This block raises interrupts for a bank of general-purpose input lines (32 by default). Each line's raw pin level is synchronised into the clock domain. It is then tested against a 3-bit event selector for that line. The selector picks falling edge, rising edge, either edge, low level or high level. A detected event sets a sticky per-line pending bit. Pending bits are kept whether or not the line is enabled.

Software enables lines through a set port and disables them through a clear port, each taking a bit vector and a write strobe. It collects pending bits by pulsing a read strobe. The pending vector is presented on the read-data output during that cycle and is wiped at the closing clock edge, so no separate acknowledge exists. One interrupt output serves the whole bank and is high whenever an enabled line has a pending bit. The per-line event selectors come from configuration storage outside this block.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: While and directly after reset, the pending vector and the enable vector read 0 and the interrupt output is low.
- R2: A cycle with the set strobe high ORs its data into the enable vector at the clock edge. Enable bits that are not addressed keep their value, and without a strobe the enable vector holds.
- R3: A cycle with the clear strobe high clears each enable bit whose data bit is 1. When the same bit is both set and cleared in one cycle, the clear wins.
- R4: A pin change becomes a pending bit at the third rising clock edge after the change, because of two synchroniser stages and one pending register.
- R5: Selector value 0 flags high-to-low transitions only, 1 flags low-to-high transitions only, and 2 flags both. Each transition flags once.
- R6: Selector value 3 sets the pending bit on every cycle the synchronised level is 0, and value 4 does so on every cycle it is 1. The bit therefore returns right after a read while the level persists. A selector change takes effect at the next clock edge.
- R7: Selector values 5, 6 and 7 never set a pending bit, whatever the pin does.
- R8: A pending bit is set for a line whose enable bit is 0, and it stays set until a read.
- R9: The read-data output always shows the pending vector. A cycle with the read strobe high clears every pending bit at its closing edge, and pending bits never clear without a read.
- R10: An event detected in the same cycle as a read is absent from the value returned by that read, and its bit is set after the edge.
- R11: The interrupt output is high exactly when the bitwise AND of the pending vector and the enable vector is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_LINES | Raw, asynchronous pin levels |
| evt_sel | input | 3*NUM_LINES | Per-line event selector; line i uses bits [3i+2:3i] |
| en_set_wr | input | 1 | Write strobe for the set port |
| en_set_data | input | NUM_LINES | Enable bits to set (1 = set) |
| en_clr_wr | input | 1 | Write strobe for the clear port |
| en_clr_data | input | NUM_LINES | Enable bits to clear (1 = clear) |
| pend_rd | input | 1 | Read strobe; clears pending bits at the edge |
| pend_rdata | output | NUM_LINES | Current pending vector |
| en_rdata | output | NUM_LINES | Current enable vector |
| irq | output | 1 | Bank interrupt |

## Verification
Each result has a known due cycle. A write to the enable vector shows one edge after its strobe. A pin transition shows as a pending bit on the third edge, and a level-selector change shows on the next edge. The read value is valid during the strobe cycle itself, and the interrupt follows the registers with no further delay. The driver counts exactly those edges before it queues an expectation, and the monitor compares at the following falling edge, away from any input change. The checks one and two edges after a pin change assert that the bit is still clear, so a shorter or longer pipeline also fails.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        EVT_FALL = 3'd0,
        EVT_RISE = 3'd1,
        EVT_BOTH = 3'd2,
        EVT_LOW  = 3'd3,
        EVT_HIGH = 3'd4
    } evt_kind_e;

    typedef struct packed {
        logic now;
        logic last;
    } line_samp_t;

    function automatic logic evt_hit(logic [SEL_W-1:0] sel, line_samp_t s);
        logic hit;
        case (sel)
            EVT_FALL: hit = s.last & ~s.now;
            EVT_RISE: hit = ~s.last & s.now;
            EVT_BOTH: hit = s.last ^ s.now;
            EVT_LOW:  hit = ~s.now;
            EVT_HIGH: hit = s.now;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] cur,
    output logic [NUM_LINES-1:0] prev
);
    localparam int unsigned LAST = STAGES - 1;

    logic [NUM_LINES-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pin_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[k] <= '0;
            else     chain[k] <= chain[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[LAST];
    end

    assign cur = chain[LAST];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic [SEL_W*NUM_LINES-1:0] evt_sel,
    input  logic [NUM_LINES-1:0]       cur,
    input  logic [NUM_LINES-1:0]       prev,
    output logic [NUM_LINES-1:0]       hit
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        line_samp_t samp;
        assign samp.now  = cur[i];
        assign samp.last = prev[i];
        assign hit[i] = evt_hit(evt_sel[i*SEL_W +: SEL_W], samp);
    end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] hit,
    input  logic                 pend_rd,
    input  logic                 en_set_wr,
    input  logic [NUM_LINES-1:0] en_set_data,
    input  logic                 en_clr_wr,
    input  logic [NUM_LINES-1:0] en_clr_data,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] en_q
);
    logic [NUM_LINES-1:0] set_v, clr_v, keep_v;

    assign set_v  = en_set_wr ? en_set_data : '0;
    assign clr_v  = en_clr_wr ? en_clr_data : '0;
    assign keep_v = pend_rd   ? '0 : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= keep_v | hit;
            en_q   <= (en_q | set_v) & ~clr_v;
        end
    end
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_LINES-1:0]       pin_in,
    input  logic [SEL_W*NUM_LINES-1:0] evt_sel,
    input  logic                       en_set_wr,
    input  logic [NUM_LINES-1:0]       en_set_data,
    input  logic                       en_clr_wr,
    input  logic [NUM_LINES-1:0]       en_clr_data,
    input  logic                       pend_rd,
    output logic [NUM_LINES-1:0]       pend_rdata,
    output logic [NUM_LINES-1:0]       en_rdata,
    output logic                       irq
);
    logic [NUM_LINES-1:0] cur, prev, hit, pend_q, en_q;

    gpio_evt_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cur(cur), .prev(prev)
    );

    gpio_evt_detect #(.NUM_LINES(NUM_LINES)) detect_i (
        .evt_sel(evt_sel), .cur(cur), .prev(prev), .hit(hit)
    );

    gpio_evt_regs #(.NUM_LINES(NUM_LINES)) regs_i (
        .clk(clk), .rst(rst), .hit(hit), .pend_rd(pend_rd),
        .en_set_wr(en_set_wr), .en_set_data(en_set_data),
        .en_clr_wr(en_clr_wr), .en_clr_data(en_clr_data),
        .pend_q(pend_q), .en_q(en_q)
    );

    assign pend_rdata = pend_q;
    assign en_rdata   = en_q;
    assign irq        = |(pend_q & en_q);
endmodule

// File: rtl/gpio_evt_ctrl_chk.sv
module gpio_evt_ctrl_chk #(
    parameter int unsigned NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en_set_wr,
    input logic [NUM_LINES-1:0] en_set_data,
    input logic                 en_clr_wr,
    input logic [NUM_LINES-1:0] en_clr_data,
    input logic                 pend_rd,
    input logic [NUM_LINES-1:0] pend_rdata,
    input logic [NUM_LINES-1:0] en_rdata,
    input logic                 irq
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pend_rdata == '0 && en_rdata == '0));

    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (en_set_wr && !en_clr_wr) |=> ((en_rdata & $past(en_set_data)) == $past(en_set_data)));

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!en_set_wr && !en_clr_wr) |=> $stable(en_rdata));

    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        en_clr_wr |=> ((en_rdata & $past(en_clr_data)) == '0));

    p_sticky_pend_r9: assert property (@(posedge clk) disable iff (rst)
        !pend_rd |=> ((pend_rdata & $past(pend_rdata)) == $past(pend_rdata)));

    p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
        irq == (|(pend_rdata & en_rdata)));
endmodule

bind gpio_evt_ctrl gpio_evt_ctrl_chk #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk(clk), .rst(rst),
    .en_set_wr(en_set_wr), .en_set_data(en_set_data),
    .en_clr_wr(en_clr_wr), .en_clr_data(en_clr_data),
    .pend_rd(pend_rd), .pend_rdata(pend_rdata),
    .en_rdata(en_rdata), .irq(irq)
);

// File: tb/gpio_evt_ctrl_tb_top.sv
module gpio_evt_ctrl_tb_top;
    localparam int unsigned NL       = 32;
    localparam time         CLK_PER  = 10ns;
    localparam int unsigned WDOG_MAX = 20000;

    typedef struct {
        string       tag;
        logic [31:0] pend;
        logic [31:0] en;
        logic        irq;
    } sb_item_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NL-1:0]   pin_in = '0;
    logic [3*NL-1:0] evt_sel;
    logic            en_set_wr = 1'b0, en_clr_wr = 1'b0, pend_rd = 1'b0;
    logic [NL-1:0]   en_set_data = '0, en_clr_data = '0;
    logic [NL-1:0]   pend_rdata, en_rdata;
    logic            irq;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    logic [31:0] exp_en = '0;
    sb_item_t    sb_q[$];
    bit          done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    gpio_evt_ctrl #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .evt_sel(evt_sel),
        .en_set_wr(en_set_wr), .en_set_data(en_set_data),
        .en_clr_wr(en_clr_wr), .en_clr_data(en_clr_data),
        .pend_rd(pend_rd), .pend_rdata(pend_rdata),
        .en_rdata(en_rdata), .irq(irq)
    );

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_out(string tag, logic [31:0] p, logic ib);
        sb_item_t it;
        it.tag = tag; it.pend = p; it.en = exp_en; it.irq = ib;
        sb_q.push_back(it);
    endtask

    task automatic set_sel(int line, logic [2:0] v);
        evt_sel[line*3 +: 3] = v;
    endtask

    task automatic do_read();
        pend_rd = 1'b1;
        tick();
        pend_rd = 1'b0;
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (pend_rdata !== it.pend || en_rdata !== it.en || irq !== it.irq) begin
                fails++;
                $display("FAIL %s: got pend=%h en=%h irq=%b, expected pend=%h en=%h irq=%b",
                         it.tag, pend_rdata, en_rdata, irq, it.pend, it.en, it.irq);
            end
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) evt_sel[i*3 +: 3] = 3'd5;
        tick(3);
        expect_out("R1 in reset", 32'h0, 1'b0);
        rst = 1'b0;
        tick();
        expect_out("R1 after reset", 32'h0, 1'b0);

        // R2 / R3 enable vector
        en_set_wr = 1'b1; en_set_data = 32'h0000_00F0; tick(); en_set_wr = 1'b0;
        exp_en = 32'h0000_00F0; expect_out("R2 set", 32'h0, 1'b0);
        tick(2); expect_out("R2 hold", 32'h0, 1'b0);
        en_clr_wr = 1'b1; en_clr_data = 32'h0000_0030; tick(); en_clr_wr = 1'b0;
        exp_en = 32'h0000_00C0; expect_out("R3 clear", 32'h0, 1'b0);
        en_set_wr = 1'b1; en_set_data = 32'h3; en_clr_wr = 1'b1; en_clr_data = 32'h1;
        tick(); en_set_wr = 1'b0; en_clr_wr = 1'b0;
        exp_en = 32'h0000_00C2; expect_out("R3 clear wins", 32'h0, 1'b0);

        // R4 / R5 rising edge on line 0, masked (R8)
        set_sel(0, 3'd1); pin_in[0] = 1'b1;
        tick(); expect_out("R4 latency edge1", 32'h0, 1'b0);
        tick(); expect_out("R4 latency edge2", 32'h0, 1'b0);
        tick(); expect_out("R4 rise latched, R8 masked", 32'h1, 1'b0);
        en_set_wr = 1'b1; en_set_data = 32'h1; tick(); en_set_wr = 1'b0;
        exp_en = 32'h0000_00C3; expect_out("R11 irq on enable", 32'h1, 1'b1);
        pend_rd = 1'b1; expect_out("R9 read value", 32'h1, 1'b1);
        tick(); pend_rd = 1'b0; expect_out("R9 cleared by read", 32'h0, 1'b0);
        tick(2); expect_out("R5 edge flags once", 32'h0, 1'b0);

        // R5 falling on line 1 (enabled)
        set_sel(1, 3'd0); pin_in[1] = 1'b1; tick(3);
        expect_out("R5 rise ignored in falling mode", 32'h0, 1'b0);
        pin_in[1] = 1'b0; tick(3);
        expect_out("R5 fall latched", 32'h2, 1'b1);
        do_read(); expect_out("R9 clear line1", 32'h0, 1'b0);

        // R5 both edges on line 2 (not enabled)
        set_sel(2, 3'd2); pin_in[2] = 1'b1; tick(3);
        expect_out("R5 both rise", 32'h4, 1'b0);
        do_read(); expect_out("R9 clear line2", 32'h0, 1'b0);
        pin_in[2] = 1'b0; tick(3);
        expect_out("R5 both fall", 32'h4, 1'b0);
        do_read();

        // R6 high level on line 3
        set_sel(3, 3'd4); pin_in[3] = 1'b1; tick(3);
        expect_out("R6 high level", 32'h8, 1'b0);
        do_read(); expect_out("R6 level returns after read", 32'h8, 1'b0);
        pin_in[3] = 1'b0; tick(2);
        do_read(); expect_out("R6 level gone", 32'h0, 1'b0);
        tick(); expect_out("R6 stays clear", 32'h0, 1'b0);

        // R6 low level via selector change on line 4 (pin low)
        set_sel(4, 3'd3); tick();
        expect_out("R6 low level next edge", 32'h10, 1'b0);
        set_sel(4, 3'd5); do_read();
        expect_out("R7 sel5 no event on low", 32'h0, 1'b0);

        // R7 reserved selectors on line 5
        set_sel(5, 3'd6); pin_in[5] = 1'b1; tick(3); pin_in[5] = 1'b0; tick(3);
        expect_out("R7 sel6 no event", 32'h0, 1'b0);
        set_sel(5, 3'd7); pin_in[5] = 1'b1; tick(3); pin_in[5] = 1'b0; tick(3);
        expect_out("R7 sel7 no event", 32'h0, 1'b0);

        // R10 event in read cycle on line 6 (enabled via 0xC0)
        set_sel(6, 3'd1); pin_in[6] = 1'b1; tick(2);
        pend_rd = 1'b1; expect_out("R10 read excludes event", 32'h0, 1'b0);
        tick(); pend_rd = 1'b0;
        expect_out("R10 event kept after read", 32'h40, 1'b1);

        // R11 irq follows mask removal, R8 pending stays
        en_clr_wr = 1'b1; en_clr_data = 32'h40; tick(); en_clr_wr = 1'b0;
        exp_en = 32'h0000_0083; expect_out("R11 irq drops, R8 pending kept", 32'h40, 1'b0);
        en_set_wr = 1'b1; en_set_data = 32'h40; tick(); en_set_wr = 1'b0;
        exp_en = 32'h0000_00C3; expect_out("R11 irq returns", 32'h40, 1'b1);

        @(negedge clk); #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (WDOG_MAX) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule